// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block turns single host commands (read, program, sector erase) into the pin-level bus cycles of a parallel NOR flash that shares its data lines with other traffic. For program and erase it plays out the device's unlock and command write cycles. Each write has a chip-enable lead and a write-enable low phase lasting several clocks. The block then holds the device in a status read and watches two things. The ready/busy line arrives on the top data line, because in flash mode that line is an input. Data bit 5 is the device's internal failure flag. A watchdog counter limits how long the poll may last.

Where a sector erase lands depends on a compile-time parameter. It places a block of small boot sectors either at the lowest or at the highest main-sector slot of the address space. Any other address falls into a large main sector. Lowering the flash-mode enable resets the whole block on the next clock, so a hung operation can always be cleared.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A command is taken when `cmdValid` is high while `stBusy` is low and `cmdOp` is 0 (read), 1 (program) or 2 (sector erase). Code 3, and any command presented while `stBusy` is high, is ignored and leaves the pins and status untouched. `stBusy` is high from the cycle after a command is taken until the operation ends.
- R2: Each flash write cycle holds `fCeN` low with `fWeN` high for CE_SETUP clocks. It then holds both low for WE_LOW clocks, and ends with one clock in which both are high while the data is still driven.
- R3: Program issues four writes: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the command data to the command address.
- R4: Sector erase issues six writes: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 to the sector base.
- R5: With BOOT_TOP=0, boot sectors are the 4096-word blocks inside the first 32768-word block. With BOOT_TOP=1, they lie inside the last 32768-word block. Every other address belongs to a 32768-word sector. The sector base is the address with the sector's offset bits cleared.
- R6: `busDataOe` is high only during write cycles. After the last write there is one clock with `fCeN`, `fWeN` and `fOeN` high and `busDataOe` low before `fOeN` goes low.
- R7: A read holds `fCeN` and `fOeN` low at the command address for RD_WAIT clocks. `rdData` takes data lines 14..0 as sampled in the last of those clocks, and `stDone` then sets.
- R8: After a program or erase, the block holds `fCeN` and `fOeN` low at the target, which is the command address for program and the sector base for erase. From the poll's clock RD_WAIT-1 onward, a high level on line 15 ends the operation with `stDone`.
- R9: At a sampled poll clock where line 15 is low and line 5 is high, the operation ends with `stDq5Err` set and `stDone` low.
- R10: If neither ready nor the error has been seen by poll clock TMO_CYC-1, the operation ends with `stTimeout` set.
- R11: `stDone`, `stDq5Err` and `stTimeout` hold until the next taken command, which clears all three. At most one of them is set.
- R12: While `flashModeEn` is low the block is reset: status, `rdData` and the bus controls return to idle on the next clock.
- R13: After reset all strobes are high (inactive), `busDataOe` is low and every status bit and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| flashModeEn | input | 1 | Flash mode select; low holds the block in reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 0 read, 1 program, 2 sector erase |
| cmdAddr | input | AW | Target word address |
| cmdData | input | DW | Program data |
| stBusy | output | 1 | Operation in progress |
| stDone | output | 1 | Last operation ended normally |
| stDq5Err | output | 1 | Last operation ended on the device failure bit |
| stTimeout | output | 1 | Last operation ended on the watchdog |
| rdData | output | DW | Data of the last read |
| fAddr | output | AW | Flash address lines |
| busDataOut | output | DW | Data driven onto lines DW-1..0 |
| busDataOe | output | 1 | Drive enable for `busDataOut` |
| busDataIn | input | DW+1 | Shared lines in; bit DW is ready/busy (1 = ready) |
| fCeN | output | 1 | Chip enable, active low |
| fWeN | output | 1 | Write enable, active low |
| fOeN | output | 1 | Output enable, active low |

## Verification
The embedded properties check on every cycle the invariants that hold regardless of sequence. Write enable never falls outside chip enable. The bus is never driven in the clock before output enable falls. At most one outcome bit is set. An error only rises after a busy, bit-5-high sample. The poll counter stays within its limit. Mode deselect idles the block. The command words, addresses, sector bases, pulse widths, the exact clock of the read sample and the clock on which each outcome is reported can only be shown by the bench's scenarios. There, a behavioural model predicts every pin on every clock for reads, programs, boot-region and main-region erases, early-ready, failure, watchdog and mid-operation deselect.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WLOW,
    S_WHOLD,
    S_TURN,
    S_POLL,
    S_RDWAIT
  } nfcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ceLow;
    logic weLow;
    logic oeLow;
    logic drive;
    logic loadCmd;
    logic capRead;
    logic setDone;
    logic setErr;
    logic setTmo;
  } nfcStrb_t;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;
  localparam logic [1:0] OP_NONE  = 2'd3;

endpackage

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int CE_SETUP = 1,
  parameter int WE_LOW   = 4,
  parameter int RD_WAIT  = 6,
  parameter int TMO_CYC  = 1000
) (
  input  logic       clk,
  input  logic       runN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       busRdy,
  input  logic       busDq5,
  output nfcStrb_t   strb,
  output logic [2:0] seqIdx,
  output logic       opErase,
  output logic       busy
);

  localparam int PH_A   = (CE_SETUP > WE_LOW) ? CE_SETUP : WE_LOW;
  localparam int PH_MAX = (PH_A > RD_WAIT) ? PH_A : RD_WAIT;
  localparam int CW     = $clog2(PH_MAX + 1);
  localparam int PW     = $clog2(TMO_CYC + 1);

  nfcState_e     state;
  logic [CW-1:0] phaseCnt;
  logic [PW-1:0] pollCnt;
  logic          accept;
  logic          pollLive;
  logic [2:0]    lastIdx;
  logic          finish;

  assign busy    = (state != S_IDLE);
  assign lastIdx = opErase ? 3'd5 : 3'd3;

  always_comb begin
    strb     = '0;
    accept   = (state == S_IDLE) && cmdValid && (cmdOp != OP_NONE);
    pollLive = (state == S_POLL) && (pollCnt >= PW'(RD_WAIT - 1));
    case (state)
      S_IDLE:   strb.loadCmd = accept;
      S_WSETUP: begin strb.ceLow = 1'b1; strb.drive = 1'b1; end
      S_WLOW:   begin strb.ceLow = 1'b1; strb.weLow = 1'b1; strb.drive = 1'b1; end
      S_WHOLD:  strb.drive = 1'b1;
      S_POLL: begin
        strb.ceLow = 1'b1;
        strb.oeLow = 1'b1;
        if (pollLive) begin
          if (busRdy)                             strb.setDone = 1'b1;
          else if (busDq5)                        strb.setErr  = 1'b1;
          else if (pollCnt == PW'(TMO_CYC - 1))   strb.setTmo  = 1'b1;
        end
      end
      S_RDWAIT: begin
        strb.ceLow = 1'b1;
        strb.oeLow = 1'b1;
        if (phaseCnt == CW'(RD_WAIT - 1)) begin
          strb.capRead = 1'b1;
          strb.setDone = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign finish = strb.setDone | strb.setErr | strb.setTmo;

  always_ff @(posedge clk) begin
    if (!runN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
      pollCnt  <= '0;
      seqIdx   <= '0;
      opErase  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          opErase  <= (cmdOp == OP_ERASE);
          seqIdx   <= '0;
          phaseCnt <= '0;
          state    <= (cmdOp == OP_READ) ? S_RDWAIT : S_WSETUP;
        end
        S_WSETUP: begin
          if (phaseCnt == CW'(CE_SETUP - 1)) begin
            phaseCnt <= '0;
            state    <= S_WLOW;
          end else phaseCnt <= phaseCnt + CW'(1);
        end
        S_WLOW: begin
          if (phaseCnt == CW'(WE_LOW - 1)) begin
            phaseCnt <= '0;
            state    <= S_WHOLD;
          end else phaseCnt <= phaseCnt + CW'(1);
        end
        S_WHOLD: begin
          if (seqIdx == lastIdx) state <= S_TURN;
          else begin
            seqIdx <= seqIdx + 3'd1;
            state  <= S_WSETUP;
          end
        end
        S_TURN: begin
          pollCnt <= '0;
          state   <= S_POLL;
        end
        S_POLL: begin
          pollCnt <= pollCnt + PW'(1);
          if (finish) state <= S_IDLE;
        end
        S_RDWAIT: begin
          if (strb.capRead) state <= S_IDLE;
          else phaseCnt <= phaseCnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a valid command in idle makes the block busy on the next clock
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!runN)
    (state == S_IDLE && cmdValid && cmdOp != OP_NONE) |=> busy);

  // R1: a command presented mid-operation does not change the running operation
  a_r1_op_stable: assert property (@(posedge clk) disable iff (!runN)
    (busy && $past(busy)) |-> $stable(opErase));

  // R10: the poll never runs past the watchdog limit
  a_r10_poll_bound: assert property (@(posedge clk) disable iff (!runN)
    (state == S_POLL) |-> (pollCnt < PW'(TMO_CYC)));

endmodule

// File: rtl/nfc_dpath.sv
module nfc_dpath
  import nfc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 15,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int MAIN_SEC_AW = 15,
  parameter int BOOT_SEC_AW = 12
) (
  input  logic          clk,
  input  logic          runN,
  input  nfcStrb_t      strb,
  input  logic [2:0]    seqIdx,
  input  logic          opErase,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  input  logic [DW:0]   busDataIn,
  output logic [AW-1:0] fAddr,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  output logic          fCeN,
  output logic          fWeN,
  output logic          fOeN,
  output logic [DW-1:0] rdData,
  output logic          stDone,
  output logic          stDq5Err,
  output logic          stTimeout
);

  localparam logic [AW-1:0] UNLK_A = AW'(12'h555);
  localparam logic [AW-1:0] UNLK_B = AW'(12'h2AA);
  localparam logic [DW-1:0] W_AA   = DW'(8'hAA);
  localparam logic [DW-1:0] W_55   = DW'(8'h55);
  localparam logic [DW-1:0] W_A0   = DW'(8'hA0);
  localparam logic [DW-1:0] W_80   = DW'(8'h80);
  localparam logic [DW-1:0] W_30   = DW'(8'h30);

  logic [AW-1:0] addrReg;
  logic [DW-1:0] dataReg;
  logic          inBoot;
  logic [AW-1:0] secBase;
  logic [AW-1:0] targetAddr;
  logic [AW-1:0] seqAddr;
  logic [DW-1:0] seqData;

  always_ff @(posedge clk) begin
    if (!runN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (strb.loadCmd) begin
      addrReg <= cmdAddr;
      dataReg <= cmdData;
    end
  end

  // boot-block placement variant
  generate
    if (BOOT_TOP) begin : g_bootTop
      assign inBoot = &addrReg[AW-1:MAIN_SEC_AW];
    end else begin : g_bootBottom
      assign inBoot = ~|addrReg[AW-1:MAIN_SEC_AW];
    end
  endgenerate

  assign secBase    = inBoot ? {addrReg[AW-1:BOOT_SEC_AW], {BOOT_SEC_AW{1'b0}}}
                             : {addrReg[AW-1:MAIN_SEC_AW], {MAIN_SEC_AW{1'b0}}};
  assign targetAddr = opErase ? secBase : addrReg;

  always_comb begin
    case (seqIdx)
      3'd0:    begin seqAddr = UNLK_A; seqData = W_AA; end
      3'd1:    begin seqAddr = UNLK_B; seqData = W_55; end
      3'd2:    begin seqAddr = UNLK_A; seqData = opErase ? W_80 : W_A0; end
      3'd3:    begin
        seqAddr = opErase ? UNLK_A : addrReg;
        seqData = opErase ? W_AA : dataReg;
      end
      3'd4:    begin seqAddr = UNLK_B; seqData = W_55; end
      default: begin seqAddr = secBase; seqData = W_30; end
    endcase
  end

  assign fAddr      = strb.drive ? seqAddr : targetAddr;
  assign busDataOut = seqData;
  assign busDataOe  = strb.drive;
  assign fCeN       = ~strb.ceLow;
  assign fWeN       = ~strb.weLow;
  assign fOeN       = ~strb.oeLow;

  always_ff @(posedge clk) begin
    if (!runN) begin
      rdData    <= '0;
      stDone    <= 1'b0;
      stDq5Err  <= 1'b0;
      stTimeout <= 1'b0;
    end else begin
      if (strb.capRead) rdData <= busDataIn[DW-1:0];
      if (strb.loadCmd) begin
        stDone    <= 1'b0;
        stDq5Err  <= 1'b0;
        stTimeout <= 1'b0;
      end else begin
        if (strb.setDone) stDone    <= 1'b1;
        if (strb.setErr)  stDq5Err  <= 1'b1;
        if (strb.setTmo)  stTimeout <= 1'b1;
      end
    end
  end

  // R2: write enable only ever pulses inside chip enable
  a_r2_we_in_ce: assert property (@(posedge clk) disable iff (!runN)
    !fWeN |-> !fCeN);

  // R6: the bus is released at least one clock before output enable falls
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!runN)
    (!fOeN && $past(fOeN)) |-> !$past(busDataOe));

  // R11: at most one outcome is reported
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!runN)
    $onehot0({stDone, stDq5Err, stTimeout}));

  // R9: an error rises only after a busy sample with bit 5 high
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!runN)
    $rose(stDq5Err) |-> (!$past(busDataIn[DW]) && $past(busDataIn[5])));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nfc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 15,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int MAIN_SEC_AW = 15,
  parameter int BOOT_SEC_AW = 12,
  parameter int CE_SETUP    = 1,
  parameter int WE_LOW      = 4,
  parameter int RD_WAIT     = 6,
  parameter int TMO_CYC     = 1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flashModeEn,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  output logic          stBusy,
  output logic          stDone,
  output logic          stDq5Err,
  output logic          stTimeout,
  output logic [DW-1:0] rdData,
  output logic [AW-1:0] fAddr,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  input  logic [DW:0]   busDataIn,
  output logic          fCeN,
  output logic          fWeN,
  output logic          fOeN
);

  logic       runN;
  nfcStrb_t   strb;
  logic [2:0] seqIdx;
  logic       opErase;

  assign runN = rstN & flashModeEn;

  nfc_ctrl #(
    .CE_SETUP(CE_SETUP), .WE_LOW(WE_LOW), .RD_WAIT(RD_WAIT), .TMO_CYC(TMO_CYC)
  ) u_ctrl (
    .clk(clk), .runN(runN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .busRdy(busDataIn[DW]), .busDq5(busDataIn[5]),
    .strb(strb), .seqIdx(seqIdx), .opErase(opErase), .busy(stBusy)
  );

  nfc_dpath #(
    .AW(AW), .DW(DW), .BOOT_TOP(BOOT_TOP),
    .MAIN_SEC_AW(MAIN_SEC_AW), .BOOT_SEC_AW(BOOT_SEC_AW)
  ) u_dpath (
    .clk(clk), .runN(runN), .strb(strb), .seqIdx(seqIdx), .opErase(opErase),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .busDataIn(busDataIn),
    .fAddr(fAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN), .rdData(rdData),
    .stDone(stDone), .stDq5Err(stDq5Err), .stTimeout(stTimeout)
  );

  // R12: deselecting flash mode idles the block on the next clock
  a_r12_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    !flashModeEn |=> (!stBusy && fCeN && fOeN && !busDataOe && !stDone));

endmodule

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;

  localparam int P_CES = 1;
  localparam int P_WEL = 4;
  localparam int P_RDW = 6;
  localparam int P_TMO = 1000;

  typedef struct {
    bit          ceN;
    bit          weN;
    bit          oeN;
    bit          drv;
    logic [19:0] addr;
    logic [14:0] dout;
    logic [15:0] din;
    int          tag;
  } cyc_t;

  logic        clk = 1'b0;
  logic        rstN, flashModeEn, cmdValid;
  logic [1:0]  cmdOp;
  logic [19:0] cmdAddr;
  logic [14:0] cmdData;
  logic        stBusy, stDone, stDq5Err, stTimeout;
  logic [14:0] rdData;
  logic [19:0] fAddr;
  logic [14:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn;
  logic        fCeN, fWeN, fOeN;

  cyc_t        q[$];
  bit          expDone, expErr, expTmo;
  logic [14:0] expRd;
  int          idleTag, tagOverride;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  nor_cmd_ctrl #(
    .AW(20), .DW(15), .BOOT_TOP(1'b0), .MAIN_SEC_AW(15), .BOOT_SEC_AW(12),
    .CE_SETUP(P_CES), .WE_LOW(P_WEL), .RD_WAIT(P_RDW), .TMO_CYC(P_TMO)
  ) u0 (
    .clk(clk), .rstN(rstN), .flashModeEn(flashModeEn), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .stBusy(stBusy),
    .stDone(stDone), .stDq5Err(stDq5Err), .stTimeout(stTimeout), .rdData(rdData),
    .fAddr(fAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN)
  );

  task automatic chk(bit ok, int tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R5: sector base with boot sectors in the first 32K-word block
  function automatic logic [19:0] secOf(logic [19:0] a);
    if (a[19:15] == 5'd0) return {a[19:12], 12'h000};
    return {a[19:15], 15'h0000};
  endfunction

  task automatic pushCyc(bit ceN, bit weN, bit oeN, bit drv, logic [19:0] a,
                         logic [14:0] d, logic [15:0] din, int tag);
    cyc_t c;
    c.ceN = ceN; c.weN = weN; c.oeN = oeN; c.drv = drv;
    c.addr = a; c.dout = d; c.din = din; c.tag = tag;
    q.push_back(c);
  endtask

  // R2: setup, write-enable low, hold
  task automatic pushWrite(logic [19:0] a, logic [14:0] d, int tag);
    repeat (P_CES) pushCyc(1'b0, 1'b1, 1'b1, 1'b1, a, d, 16'h0000, tag);
    repeat (P_WEL) pushCyc(1'b0, 1'b0, 1'b1, 1'b1, a, d, 16'h0000, tag);
    pushCyc(1'b1, 1'b1, 1'b1, 1'b1, a, d, 16'h0000, 2);
  endtask

  // R8 ready, R9 bit-5 failure, R10 watchdog
  task automatic pushPoll(logic [19:0] a, int readyAt, int dq5At);
    for (int c = 0; c < P_TMO; c++) begin
      bit rdy = (readyAt >= 0) && (c >= readyAt);
      bit d5  = (dq5At >= 0) && (c >= dq5At);
      pushCyc(1'b0, 1'b1, 1'b0, 1'b0, a, 15'h0, {rdy, 9'h0, d5, 5'h0}, 8);
      if (c >= P_RDW - 1) begin
        if (rdy)                   begin expDone = 1'b1; idleTag = 8;  break; end
        else if (d5)               begin expErr  = 1'b1; idleTag = 9;  break; end
        else if (c == P_TMO - 1)   begin expTmo  = 1'b1; idleTag = 10; break; end
      end
    end
  endtask

  task automatic tick();
    cyc_t c;
    int   t;
    @(negedge clk);
    if (q.size() > 0) begin
      c = q.pop_front();
      t = (tagOverride != 0) ? tagOverride : c.tag;
      chk(fCeN == c.ceN, t, "fCeN", fCeN, c.ceN);
      chk(fWeN == c.weN, t, "fWeN", fWeN, c.weN);
      chk(fOeN == c.oeN, t, "fOeN", fOeN, c.oeN);
      chk(busDataOe == c.drv, (t == 8) ? 6 : t, "busDataOe", busDataOe, c.drv);
      if (!c.ceN || c.drv) chk(fAddr == c.addr, t, "fAddr", fAddr, c.addr);
      if (c.drv) chk(busDataOut == c.dout, t, "busDataOut", busDataOut, c.dout);
      // R11: outcome bits cleared while the new command runs
      chk({stBusy, stDone, stDq5Err, stTimeout} == 4'b1000, 11, "status",
          {stBusy, stDone, stDq5Err, stTimeout}, 4'b1000);
      busDataIn = c.din;
    end else begin
      chk({fCeN, fWeN, fOeN, busDataOe} == 4'b1110, idleTag, "idle pins",
          {fCeN, fWeN, fOeN, busDataOe}, 4'b1110);
      chk({stBusy, stDone, stDq5Err, stTimeout} == {1'b0, expDone, expErr, expTmo},
          idleTag, "status", {stBusy, stDone, stDq5Err, stTimeout},
          {1'b0, expDone, expErr, expTmo});
      chk(rdData == expRd, (idleTag == 8) ? 7 : idleTag, "rdData", rdData, expRd);
      busDataIn = 16'h8000;
    end
  endtask

  task automatic issue(logic [1:0] op, logic [19:0] a, logic [14:0] d,
                       int readyAt, int dq5At, int pokeAt, bit runAll);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    expDone = 1'b0; expErr = 1'b0; expTmo = 1'b0;
    if (op == 2'd0) begin
      // R7: only the last clock of the read window is sampled
      for (int c = 0; c < P_RDW; c++)
        pushCyc(1'b0, 1'b1, 1'b0, 1'b0, a, 15'h0,
                (c == P_RDW - 1) ? {1'b1, d} : {1'b1, ~d}, 7);
      expDone = 1'b1; expRd = d; idleTag = 7;
    end else if (op == 2'd1) begin
      // R3: program unlock and command words
      pushWrite(20'h00555, 15'h00AA, 3);
      pushWrite(20'h002AA, 15'h0055, 3);
      pushWrite(20'h00555, 15'h00A0, 3);
      pushWrite(a, d, 3);
      pushCyc(1'b1, 1'b1, 1'b1, 1'b0, a, 15'h0, 16'h0000, 6); // R6 turnaround
      pushPoll(a, readyAt, dq5At);
    end else begin
      // R4: six-write erase sequence, R5: last write at the sector base
      pushWrite(20'h00555, 15'h00AA, 4);
      pushWrite(20'h002AA, 15'h0055, 4);
      pushWrite(20'h00555, 15'h0080, 4);
      pushWrite(20'h00555, 15'h00AA, 4);
      pushWrite(20'h002AA, 15'h0055, 4);
      pushWrite(secOf(a), 15'h0030, 5);
      pushCyc(1'b1, 1'b1, 1'b1, 1'b0, a, 15'h0, 16'h0000, 6);
      pushPoll(secOf(a), readyAt, dq5At);
    end
    tick();
    cmdValid = 1'b0;
    if (runAll) begin
      for (int k = 0; q.size() > 0; k++) begin
        // R1: a command presented mid-operation must not disturb the trace
        if (k == pokeAt) begin
          cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = ~a; cmdData = ~d;
        end
        tagOverride = (pokeAt >= 0 && k >= pokeAt && k < pokeAt + 4) ? 1 : 0;
        tick();
        cmdValid = 1'b0;
      end
      tagOverride = 0;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; flashModeEn = 1'b1; cmdValid = 1'b0; cmdOp = 2'd0;
    cmdAddr = '0; cmdData = '0; busDataIn = 16'h8000;
    expDone = 1'b0; expErr = 1'b0; expTmo = 1'b0; expRd = '0;
    idleTag = 13; tagOverride = 0;
    repeat (3) tick();                       // R13 reset state
    rstN = 1'b1;
    tick();

    issue(2'd0, 20'h12345, 15'h1A5A, -1, -1, -1, 1'b1);      // R7
    issue(2'd1, 20'h00ABC, 15'h3C3C, 10, -1, 9, 1'b1);        // R3 R8 R1
    cmdValid = 1'b1; cmdOp = 2'd3; cmdAddr = 20'hFFFFF; idleTag = 1;   // R1 code 3
    tick(); cmdValid = 1'b0; tick();
    issue(2'd2, 20'h01234, 15'h0, P_RDW - 1, -1, -1, 1'b1);   // R4 R5 boot region
    issue(2'd2, 20'h5ABCD, 15'h0, 20, -1, -1, 1'b1);          // R5 main sector
    issue(2'd1, 20'h7FFFF, 15'h7FFF, -1, 12, -1, 1'b1);       // R9
    issue(2'd0, 20'h00001, 15'h0F0F, -1, -1, -1, 1'b1);       // R11 clears error
    issue(2'd1, 20'h40000, 15'h1111, 3, -1, -1, 1'b1);        // R8 early ready
    issue(2'd1, 20'h22222, 15'h2222, -1, -1, -1, 1'b1);       // R10 timeout
    issue(2'd0, 20'h33333, 15'h5555, -1, -1, -1, 1'b1);       // R11 clears timeout

    issue(2'd2, 20'h0F000, 15'h0, -1, -1, -1, 1'b0);          // R12 mode off mid-op
    repeat (8) tick();
    flashModeEn = 1'b0;
    q.delete();
    expDone = 1'b0; expErr = 1'b0; expTmo = 1'b0; expRd = '0; idleTag = 12;
    tick(); tick();
    flashModeEn = 1'b1;
    tick();
    issue(2'd0, 20'h0F000, 15'h2468, -1, -1, -1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule